// File: doc/BRIEF.md
# Thread-to-Core Idle State Coordinator

This block follows the idle-state requests of the hardware threads that share one core and turns them into a single core idle state. Each thread owns a small state machine with four states: active (C0) and the progressively deeper idle states C1, C3 and C6. A thread enters an idle state through a halt command, a wait command carrying a depth hint, or a read of one of two power-level I/O ports. It returns to C0 through its wake input.

The core state is the shallowest state held by any thread, so the core is active whenever one thread is active. Only this resolved state reaches the power-saving logic, never a single thread's request. When the enhanced C1 mode is enabled, a core resolved to C1 is marked as C1E, but only while a global input reports that every other active core is also at C1 or deeper. A one-cycle strobe flags each change of the resolved state or of the C1E mark. A sticky flag records any entry request made by a thread that is not in C0, because every transition has to pass through C0.

Top module: `core_idle_coord`

## Requirements
- R1: Reset puts every thread and the core in C0 (code 2'b00), and clears the C1E mark, the change strobe and the error flag.
- R2: For a thread in C0 with no wake, a halt, or a wait with hint 2'b01, puts the thread in C1 (2'b01) at the next clock edge.
- R3: For a thread in C0 with no wake, a wait with hint 2'b10 or a shallow port read (deep select 0) gives C3 (2'b10). A wait with hint 2'b11 or a deep port read (deep select 1) gives C6 (2'b11). When several entry requests arrive in one cycle, the deepest target wins.
- R4: A wake returns its thread to C0 at the next clock edge and overrides any entry request in the same cycle. No error is raised in that case.
- R5: An entry request to a thread that is not in C0 and has no wake leaves the thread's state unchanged. It sets the error flag, and the flag stays set until reset. A wait with hint 2'b00 requests nothing. The thread never moves directly between two non-C0 states.
- R6: The core state equals the numeric minimum of all thread state codes, and it is updated at the same clock edge as the thread states.
- R7: The C1E mark is high exactly when the core state is C1, C1E is enabled, and the other-cores input is high, all sampled at the same edge.
- R8: The change strobe is high for the one cycle after an edge at which the core state or the C1E mark changed, and it is low otherwise.
- R9: The state of thread i appears on threadState bits [2i+1:2i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| haltReq | input | NUM_THREADS | Halt command, one bit per thread |
| waitReq | input | NUM_THREADS | Wait command, one bit per thread |
| waitHint | input | 2*NUM_THREADS | Depth hint of the wait command, 2 bits per thread |
| ioRdReq | input | NUM_THREADS | Power-level port read, one bit per thread |
| ioRdDeep | input | NUM_THREADS | Selects the deep port (C6) over the shallow port (C3) |
| wake | input | NUM_THREADS | Return the thread to C0 |
| c1eEnable | input | 1 | Enables the promotion of C1 to C1E |
| othersAtC1 | input | 1 | All other active cores are at C1 or deeper |
| coreState | output | 2 | Resolved core state code |
| coreC1e | output | 1 | Core resolved to the enhanced C1 state |
| stateChange | output | 1 | One-cycle strobe on a change of state or C1E |
| protoErr | output | 1 | Sticky flag for an entry request outside C0 |
| threadState | output | 2*NUM_THREADS | State code of each thread |

## Verification
The main function is driven by directed sequences and by a long random stream. The directed sequences split the three entry paths: halt and wait hints give C1, the shallow and deep port reads give C3 and C6, and combined requests show that the deepest target wins. Mixed thread states, one thread deep while the other is shallow or active, show whether the core follows the minimum and not the maximum or one fixed thread. Toggling the other-cores and enable inputs while the core stays in C1 separates a C1E change from a core-state change on the strobe. Entry requests sent to threads already idle, alone and together with a wake, show the difference between an ignored request that raises the error flag and a request that the wake overrides.

// File: rtl/cidle_pkg.sv
package cidle_pkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_C0 = 2'b00,
    ST_C1 = 2'b01,
    ST_C3 = 2'b10,
    ST_C6 = 2'b11
  } idleState_e;

  // per-thread command from control to datapath
  typedef struct packed {
    logic       wakeStb;
    logic       enterStb;
    idleState_e target;
  } thrCmd_t;

endpackage

// File: rtl/cidle_ctrl.sv
module cidle_ctrl
  import cidle_pkg::*;
#(
  parameter int NUM_THREADS = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_THREADS-1:0]            haltReq,
  input  logic [NUM_THREADS-1:0]            waitReq,
  input  logic [STATE_W*NUM_THREADS-1:0]    waitHint,
  input  logic [NUM_THREADS-1:0]            ioRdReq,
  input  logic [NUM_THREADS-1:0]            ioRdDeep,
  input  logic [NUM_THREADS-1:0]            wake,
  input  idleState_e [NUM_THREADS-1:0]      threadState,
  output thrCmd_t [NUM_THREADS-1:0]         cmd,
  output logic                              protoErr
);

  logic [NUM_THREADS-1:0] badReq;

  for (genvar g = 0; g < NUM_THREADS; g++) begin : gThr
    logic [STATE_W-1:0] tgt;
    logic [STATE_W-1:0] hint;
    logic               wantEntry;

    assign hint = waitHint[STATE_W*g +: STATE_W];

    // deepest requested target wins
    always_comb begin
      tgt = ST_C0;
      if (haltReq[g]) tgt = ST_C1;
      if (waitReq[g] && (hint > tgt)) tgt = hint;
      if (ioRdReq[g]) begin
        if (ioRdDeep[g]) tgt = ST_C6;
        else if (tgt < ST_C3) tgt = ST_C3;
      end
    end

    assign wantEntry       = (tgt != ST_C0);
    assign cmd[g].wakeStb  = wake[g];
    assign cmd[g].enterStb = !wake[g] && wantEntry && (threadState[g] == ST_C0);
    assign cmd[g].target   = idleState_e'(tgt);
    assign badReq[g]       = !wake[g] && wantEntry && (threadState[g] != ST_C0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) protoErr <= 1'b0;
    else if (|badReq) protoErr <= 1'b1;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr); // R5

  AST_ERR_ON_BAD: assert property (@(posedge clk) disable iff (!rstN)
    (|badReq) |=> protoErr); // R5

endmodule

// File: rtl/cidle_datapath.sv
module cidle_datapath
  import cidle_pkg::*;
#(
  parameter int NUM_THREADS = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  thrCmd_t [NUM_THREADS-1:0]     cmd,
  input  logic                          c1eEnable,
  input  logic                          othersAtC1,
  output idleState_e [NUM_THREADS-1:0]  threadState,
  output idleState_e                    coreState,
  output logic                          coreC1e,
  output logic                          stateChange
);

  idleState_e [NUM_THREADS-1:0] thrQ;
  idleState_e [NUM_THREADS-1:0] thrNext;
  idleState_e                   coreQ;
  idleState_e                   coreNext;
  logic                         c1eQ;
  logic                         c1eNext;
  logic                         chgQ;

  for (genvar g = 0; g < NUM_THREADS; g++) begin : gThr
    always_comb begin
      thrNext[g] = thrQ[g];
      if (cmd[g].wakeStb)       thrNext[g] = ST_C0;
      else if (cmd[g].enterStb) thrNext[g] = cmd[g].target;
    end

    always_ff @(posedge clk) begin
      if (!rstN) thrQ[g] <= ST_C0;
      else       thrQ[g] <= thrNext[g];
    end

    AST_WAKE_TO_C0: assert property (@(posedge clk) disable iff (!rstN)
      cmd[g].wakeStb |=> (thrQ[g] == ST_C0)); // R4

    AST_NO_DIRECT_HOP: assert property (@(posedge clk) disable iff (!rstN)
      (thrQ[g] != ST_C0) |=> ((thrQ[g] == $past(thrQ[g])) || (thrQ[g] == ST_C0))); // R5

    AST_CORE_NOT_DEEPER: assert property (@(posedge clk) disable iff (!rstN)
      coreQ <= thrQ[g]); // R6
  end

  // shallowest thread state
  always_comb begin
    coreNext = ST_C6;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (thrNext[i] < coreNext) coreNext = thrNext[i];
    end
  end

  assign c1eNext = (coreNext == ST_C1) && c1eEnable && othersAtC1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreQ <= ST_C0;
      c1eQ  <= 1'b0;
      chgQ  <= 1'b0;
    end else begin
      coreQ <= coreNext;
      c1eQ  <= c1eNext;
      chgQ  <= (coreNext != coreQ) || (c1eNext != c1eQ);
    end
  end

  assign threadState = thrQ;
  assign coreState   = coreQ;
  assign coreC1e     = c1eQ;
  assign stateChange = chgQ;

  AST_C1E_NEEDS_C1: assert property (@(posedge clk) disable iff (!rstN)
    c1eQ |-> (coreQ == ST_C1)); // R7

  AST_CHANGE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    chgQ |-> ((coreQ != $past(coreQ)) || (c1eQ != $past(c1eQ)))); // R8

endmodule

// File: rtl/core_idle_coord.sv
module core_idle_coord
  import cidle_pkg::*;
#(
  parameter int NUM_THREADS = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_THREADS-1:0]          haltReq,
  input  logic [NUM_THREADS-1:0]          waitReq,
  input  logic [2*NUM_THREADS-1:0]        waitHint,
  input  logic [NUM_THREADS-1:0]          ioRdReq,
  input  logic [NUM_THREADS-1:0]          ioRdDeep,
  input  logic [NUM_THREADS-1:0]          wake,
  input  logic                            c1eEnable,
  input  logic                            othersAtC1,
  output logic [1:0]                      coreState,
  output logic                            coreC1e,
  output logic                            stateChange,
  output logic                            protoErr,
  output logic [2*NUM_THREADS-1:0]        threadState
);

  thrCmd_t    [NUM_THREADS-1:0] cmd;
  idleState_e [NUM_THREADS-1:0] thrState;
  idleState_e                   coreSt;

  cidle_ctrl #(.NUM_THREADS(NUM_THREADS)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .haltReq     (haltReq),
    .waitReq     (waitReq),
    .waitHint    (waitHint),
    .ioRdReq     (ioRdReq),
    .ioRdDeep    (ioRdDeep),
    .wake        (wake),
    .threadState (thrState),
    .cmd         (cmd),
    .protoErr    (protoErr)
  );

  cidle_datapath #(.NUM_THREADS(NUM_THREADS)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .c1eEnable   (c1eEnable),
    .othersAtC1  (othersAtC1),
    .threadState (thrState),
    .coreState   (coreSt),
    .coreC1e     (coreC1e),
    .stateChange (stateChange)
  );

  assign coreState   = coreSt;
  assign threadState = thrState;

endmodule

// File: tb/tb_core_idle_coord.sv
module tb_core_idle_coord;

  localparam int NT = 2;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NT-1:0] haltReq, waitReq, ioRdReq, ioRdDeep, wake;
  logic [2*NT-1:0] waitHint;
  logic          c1eEnable, othersAtC1;
  logic [1:0]    coreState;
  logic          coreC1e, stateChange, protoErr;
  logic [2*NT-1:0] threadState;

  int nChecks = 0;
  int nFails  = 0;

  logic [1:0] expThr [NT];
  logic [1:0] expCore;
  logic       expC1e, expChg, expErr;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_idle_coord #(.NUM_THREADS(NT)) dut (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .waitReq(waitReq),
    .waitHint(waitHint), .ioRdReq(ioRdReq), .ioRdDeep(ioRdDeep),
    .wake(wake), .c1eEnable(c1eEnable), .othersAtC1(othersAtC1),
    .coreState(coreState), .coreC1e(coreC1e), .stateChange(stateChange),
    .protoErr(protoErr), .threadState(threadState)
  );

  function automatic logic [1:0] targetOf(logic h, logic w, logic [1:0] hint,
                                          logic io, logic deep);
    logic [1:0] t = 2'b00;
    if (h) t = 2'b01;
    if (w && hint > t) t = hint;
    if (io) begin
      if (deep) t = 2'b11;
      else if (t < 2'b10) t = 2'b10;
    end
    return t;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    for (int i = 0; i < NT; i++)
      check(tag, $sformatf("thread%0d state (R9)", i), threadState[2*i +: 2], expThr[i]);
    check("R6", "core state", coreState, expCore);
    check("R7", "C1E mark", coreC1e, expC1e);
    check("R8", "change strobe", stateChange, expChg);
    check("R5", "error flag", protoErr, expErr);
  endtask

  task automatic clearInputs();
    haltReq = '0; waitReq = '0; waitHint = '0; ioRdReq = '0;
    ioRdDeep = '0; wake = '0;
  endtask

  // advance one clock with the present inputs and compare
  task automatic step(string tag);
    logic [1:0] nCore = 2'b11;
    logic       nC1e;
    for (int i = 0; i < NT; i++) begin
      logic [1:0] t = targetOf(haltReq[i], waitReq[i], waitHint[2*i +: 2],
                               ioRdReq[i], ioRdDeep[i]);
      if (wake[i]) expThr[i] = 2'b00;
      else if (t != 2'b00) begin
        if (expThr[i] == 2'b00) expThr[i] = t;
        else expErr = 1'b1;
      end
      if (expThr[i] < nCore) nCore = expThr[i];
    end
    nC1e    = (nCore == 2'b01) && c1eEnable && othersAtC1;
    expChg  = (nCore != expCore) || (nC1e != expC1e);
    expCore = nCore;
    expC1e  = nC1e;
    @(negedge clk);
    checkAll(tag);
  endtask

  task automatic doReset();
    clearInputs();
    c1eEnable = 1'b0; othersAtC1 = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NT; i++) expThr[i] = 2'b00;
    expCore = 2'b00; expC1e = 1'b0; expChg = 1'b0; expErr = 1'b0;
    checkAll("R1");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    doReset();
    step("R1");

    // R2: halt on thread 0, wait hint C1 on thread 1
    haltReq[0] = 1; step("R2"); clearInputs();
    waitReq[1] = 1; waitHint[3:2] = 2'b01; step("R2"); clearInputs();
    wake = '1; step("R4"); clearInputs();

    // R3: shallow port read and deep wait hint, core follows minimum
    ioRdReq[0] = 1; ioRdDeep[0] = 0; step("R3"); clearInputs();
    waitReq[1] = 1; waitHint[3:2] = 2'b11; step("R3"); clearInputs();
    // R5: thread 0 in C3 gets a halt, ignored and flagged
    haltReq[0] = 1; step("R5"); clearInputs();
    // R4: wake plus entry in the same cycle
    wake[0] = 1; haltReq[0] = 1; ioRdReq[0] = 1; step("R4"); clearInputs();
    // R3: combined requests, deepest wins
    haltReq[0] = 1; ioRdReq[0] = 1; ioRdDeep[0] = 1; step("R3"); clearInputs();
    wake = '1; step("R4"); clearInputs();
    // R5: hint 00 requests nothing
    waitReq[0] = 1; waitHint[1:0] = 2'b00; step("R5"); clearInputs();

    // R7: C1E promotion and withdrawal
    doReset();
    c1eEnable = 1; othersAtC1 = 1;
    haltReq = '1; step("R7"); clearInputs();
    step("R8");
    othersAtC1 = 0; step("R7");
    othersAtC1 = 1; step("R7");
    c1eEnable = 0; step("R7");
    ioRdReq[1] = 1; ioRdDeep[1] = 1; step("R5"); clearInputs();

    // random stream
    doReset();
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < NT; i++) begin
        haltReq[i]  = ($urandom % 10) == 0;
        waitReq[i]  = ($urandom % 10) == 0;
        waitHint[2*i +: 2] = 2'($urandom % 4);
        ioRdReq[i]  = ($urandom % 12) == 0;
        ioRdDeep[i] = $urandom % 2;
        wake[i]     = ($urandom % 7) == 0;
      end
      c1eEnable  = ($urandom % 4) != 0;
      othersAtC1 = $urandom % 2;
      step("R9");
      if (n % 700 == 699) doReset();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule